// File: doc/BRIEF.md
# Conditional Branch and Loop Unit

This block works out the next program counter for a 16-bit processor's relative branches and its counted loop instruction. It is purely combinational. The decode stage gives it the current PC, the opcode byte, the register-select byte of a loop instruction, a short and a long displacement, the four condition flags (Z, N, V, C) and the value of the loop counter register. It returns the next PC, a taken flag and a hit flag that says whether it recognised the opcode. For loop instructions it also returns the decremented counter with its write enable and register index, and the new Z flag with its own write enable.

There are two branch forms. The short form is two bytes with an 8-bit signed displacement. The long form is three bytes with a 16-bit signed displacement. In both, the low opcode nibble selects one of sixteen conditions, some signed and some unsigned. The counted loop is three bytes. Before it decrements, it tests an early-exit condition on Z. If that condition holds, the instruction falls through and leaves the counter and Z unchanged. Otherwise it decrements the counter, loads Z from the result, and branches while the result is non-zero.

Top module: `branch_loop_unit`

## Requirements
- R1: Opcodes 0x20..0x2F are short branches. When taken, next PC = PC + 2 + sign-extended `disp_short_i`. When not taken, next PC = PC + 2.
- R2: Opcodes 0x30..0x3F are long branches. When taken, next PC = PC + 3 + `disp_long_i` (signed). When not taken, next PC = PC + 3.
- R3: The low opcode nibble selects the condition. The simple codes are:
  - 0: always
  - 1: never
  - 2: C=0 and Z=0
  - 3: C=1 or Z=1
  - 4: C=0
  - 5: C=1
  - 6: Z=0
  - 7: Z=1
  - 8: V=0
  - 9: V=1
  - A: N=0
  - B: N=1
- R4: The signed codes are:
  - C: N equals V
  - D: N differs from V
  - E: Z=0 and N equals V
  - F: Z=1 or N differs from V
- R5: For both branch forms, `cnt_we_o` and `z_we_o` stay low, and `z_o` equals `z_i`.
- R6: A loop instruction is recognised only when:
  - the opcode is 0x01, 0x06 or 0x07, and
  - `loop_reg_i` lies in 0xB8..0xBF.
  
  When recognised, `cnt_idx_o` equals `loop_reg_i[2:0]`.
- R7: The loop exit condition is "never" for 0x01, Z=0 for 0x06 and Z=1 for 0x07. When it holds:
  - next PC = PC + 3 and `taken_o` = 0;
  - `cnt_we_o` and `z_we_o` are 0;
  - `cnt_o` equals `cnt_i` and `z_o` equals `z_i`.
- R8: When the loop exit condition does not hold:
  - `cnt_o` = `cnt_i` - 1 (mod 2^16), with `cnt_we_o` = 1;
  - `z_o` = 1 exactly when that result is zero, with `z_we_o` = 1;
  - the branch to PC + 3 + sign-extended `disp_short_i` is taken only when the result is non-zero, and otherwise next PC = PC + 3.
- R9: All PC arithmetic wraps modulo 2^16.
- R10: For any other opcode, or a loop opcode with `loop_reg_i` outside 0xB8..0xBF:
  - `hit_o`, `taken_o`, `cnt_we_o` and `z_we_o` are 0;
  - next PC equals PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 16 | Address of the current instruction |
| opcode_i | input | 8 | First instruction byte |
| loop_reg_i | input | 8 | Second byte of a loop instruction (register select) |
| disp_short_i | input | 8 | 8-bit signed displacement (short branch and loop) |
| disp_long_i | input | 16 | 16-bit signed displacement (long branch) |
| z_i | input | 1 | Zero flag |
| n_i | input | 1 | Negative flag |
| v_i | input | 1 | Overflow flag |
| c_i | input | 1 | Carry flag |
| cnt_i | input | 16 | Current value of the selected loop counter register |
| next_pc_o | output | 16 | Next program counter |
| taken_o | output | 1 | Branch or loop jump taken |
| hit_o | output | 1 | Opcode recognised by this unit |
| cnt_o | output | 16 | New counter value |
| cnt_we_o | output | 1 | Counter write enable |
| cnt_idx_o | output | 3 | Counter register index |
| z_o | output | 1 | New Z flag |
| z_we_o | output | 1 | Z flag write enable |

## Verification
The checker continuously enforces the properties that hold whatever the inputs:
- branches never write the counter or Z;
- a counter write is always the input minus one, and comes with Z set exactly when the input was one;
- a loop jump is taken only when the written counter is non-zero;
- an unrecognised opcode leaves every output inert;
- the fixed "always" and "never" codes decide as expected;
- an untaken short branch lands two bytes ahead.

Only the bench scenarios can show that each of the sixteen condition codes decides correctly for every flag combination, and that displacements are sign-extended correctly. They also cover wraparound at the top of the address space and the register index decoded for every select byte.

// File: rtl/bl_pkg.sv
package bl_pkg;

  typedef enum logic [3:0] {
    CC_ALWAYS = 4'h0, CC_NEVER = 4'h1, CC_HI = 4'h2, CC_LS = 4'h3,
    CC_CCLR   = 4'h4, CC_CSET  = 4'h5, CC_NE = 4'h6, CC_EQ = 4'h7,
    CC_VCLR   = 4'h8, CC_VSET  = 4'h9, CC_PL = 4'hA, CC_MI = 4'hB,
    CC_GE     = 4'hC, CC_LT    = 4'hD, CC_GT = 4'hE, CC_LE = 4'hF
  } cond_e;

  typedef enum logic [1:0] {K_MISS, K_SHORT, K_LONG, K_LOOP} kind_e;

  typedef enum logic [1:0] {EX_NONE, EX_ZCLR, EX_ZSET} loop_exit_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } flags_t;

  localparam logic [3:0] OP_SHORT_HI  = 4'h2;
  localparam logic [3:0] OP_LONG_HI   = 4'h3;
  localparam logic [7:0] OP_LOOP_ANY  = 8'h01;
  localparam logic [7:0] OP_LOOP_ZCLR = 8'h06;
  localparam logic [7:0] OP_LOOP_ZSET = 8'h07;
  localparam logic [4:0] LOOP_SEL_TAG = 5'b10111;
  localparam int         IDX_W        = 3;
  localparam int         DSHORT_W     = 8;

endpackage

// File: rtl/bl_cond_eval.sv
module bl_cond_eval
  import bl_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flags_i,
  output logic   pass_o
);
  logic nv_eq;
  assign nv_eq = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (cond_i)
      CC_ALWAYS: pass_o = 1'b1;
      CC_NEVER:  pass_o = 1'b0;
      CC_HI:     pass_o = ~flags_i.c & ~flags_i.z;
      CC_LS:     pass_o = flags_i.c | flags_i.z;
      CC_CCLR:   pass_o = ~flags_i.c;
      CC_CSET:   pass_o = flags_i.c;
      CC_NE:     pass_o = ~flags_i.z;
      CC_EQ:     pass_o = flags_i.z;
      CC_VCLR:   pass_o = ~flags_i.v;
      CC_VSET:   pass_o = flags_i.v;
      CC_PL:     pass_o = ~flags_i.n;
      CC_MI:     pass_o = flags_i.n;
      CC_GE:     pass_o = nv_eq;
      CC_LT:     pass_o = ~nv_eq;
      CC_GT:     pass_o = ~flags_i.z & nv_eq;
      CC_LE:     pass_o = flags_i.z | ~nv_eq;
      default:   pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bl_target_add.sv
module bl_target_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] pc_i,
  input  logic [1:0]   len_i,
  input  logic [W-1:0] disp_i,
  input  logic         take_i,
  output logic [W-1:0] next_pc_o
);
  logic [W-1:0] seq_pc;
  logic [W-1:0] tgt_pc;

  // displacement is relative to the address after the instruction
  assign seq_pc    = pc_i + {{(W-2){1'b0}}, len_i};
  assign tgt_pc    = seq_pc + disp_i;
  assign next_pc_o = take_i ? tgt_pc : seq_pc;
endmodule

// File: rtl/bl_loop_ctrl.sv
module bl_loop_ctrl
  import bl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             en_i,
  input  loop_exit_e       mode_i,
  input  logic             z_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_we_o,
  output logic             z_o,
  output logic             z_we_o,
  output logic             take_o
);
  logic             early_exit;
  logic             run;
  logic [CNT_W-1:0] dec;

  always_comb begin
    unique case (mode_i)
      EX_ZCLR: early_exit = ~z_i;
      EX_ZSET: early_exit = z_i;
      default: early_exit = 1'b0;
    endcase
  end

  assign dec      = cnt_i - {{(CNT_W-1){1'b0}}, 1'b1};
  assign run      = en_i & ~early_exit;
  assign cnt_o    = run ? dec : cnt_i;
  assign cnt_we_o = run;
  assign z_o      = run ? ~|dec : z_i;
  assign z_we_o   = run;
  assign take_o   = run & |dec;
endmodule

// File: rtl/branch_loop_unit.sv
module branch_loop_unit
  import bl_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [7:0]       opcode_i,
  input  logic [7:0]       loop_reg_i,
  input  logic [7:0]       disp_short_i,
  input  logic [PC_W-1:0]  disp_long_i,
  input  logic             z_i,
  input  logic             n_i,
  input  logic             v_i,
  input  logic             c_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             taken_o,
  output logic             hit_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_we_o,
  output logic [2:0]       cnt_idx_o,
  output logic             z_o,
  output logic             z_we_o
);
  localparam int EXT_W = PC_W - DSHORT_W;

  kind_e        kind;
  loop_exit_e   exit_mode;
  flags_t       flags;
  logic         cond_pass;
  logic         br_take;
  logic         lp_take;
  logic [1:0]   ins_len;
  logic [PC_W-1:0] disp_sx;
  logic [PC_W-1:0] disp_sel;
  logic [PC_W-1:0] tgt_pc;

  assign flags = '{z: z_i, n: n_i, v: v_i, c: c_i};

  // instruction class
  always_comb begin
    kind      = K_MISS;
    exit_mode = EX_NONE;
    if (opcode_i[7:4] == OP_SHORT_HI) begin
      kind = K_SHORT;
    end else if (opcode_i[7:4] == OP_LONG_HI) begin
      kind = K_LONG;
    end else if (loop_reg_i[7:3] == LOOP_SEL_TAG) begin
      unique case (opcode_i)
        OP_LOOP_ANY:  begin kind = K_LOOP; exit_mode = EX_NONE; end
        OP_LOOP_ZCLR: begin kind = K_LOOP; exit_mode = EX_ZCLR; end
        OP_LOOP_ZSET: begin kind = K_LOOP; exit_mode = EX_ZSET; end
        default:      kind = K_MISS;
      endcase
    end
  end

  generate
    if (EXT_W > 0) begin : g_sext
      assign disp_sx = {{EXT_W{disp_short_i[DSHORT_W-1]}}, disp_short_i};
    end else begin : g_trunc
      assign disp_sx = disp_short_i[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (kind)
      K_SHORT: begin ins_len = 2'd2; disp_sel = disp_sx;     end
      K_LONG:  begin ins_len = 2'd3; disp_sel = disp_long_i; end
      K_LOOP:  begin ins_len = 2'd3; disp_sel = disp_sx;     end
      default: begin ins_len = 2'd0; disp_sel = '0;          end
    endcase
  end

  bl_cond_eval u_cond (
    .cond_i  (cond_e'(opcode_i[3:0])),
    .flags_i (flags),
    .pass_o  (cond_pass)
  );

  assign br_take = ((kind == K_SHORT) || (kind == K_LONG)) && cond_pass;

  bl_loop_ctrl #(.CNT_W(CNT_W)) u_loop (
    .en_i     (kind == K_LOOP),
    .mode_i   (exit_mode),
    .z_i      (z_i),
    .cnt_i    (cnt_i),
    .cnt_o    (cnt_o),
    .cnt_we_o (cnt_we_o),
    .z_o      (z_o),
    .z_we_o   (z_we_o),
    .take_o   (lp_take)
  );

  bl_target_add #(.W(PC_W)) u_tgt (
    .pc_i      (pc_i),
    .len_i     (ins_len),
    .disp_i    (disp_sel),
    .take_i    (br_take | lp_take),
    .next_pc_o (tgt_pc)
  );

  assign next_pc_o = tgt_pc;
  assign taken_o   = br_take | lp_take;
  assign hit_o     = (kind != K_MISS);
  assign cnt_idx_o = (kind == K_LOOP) ? loop_reg_i[IDX_W-1:0] : '0;
endmodule

// File: rtl/bl_checker.sv
module bl_checker #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input logic [PC_W-1:0]  pc_i,
  input logic [7:0]       opcode_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [PC_W-1:0]  next_pc_o,
  input logic             taken_o,
  input logic             hit_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             cnt_we_o,
  input logic             z_o,
  input logic             z_we_o
);
  logic is_branch;
  assign is_branch = (opcode_i[7:5] == 3'b001);

  always_comb begin
    if (is_branch) begin
      a_r5_branch_no_write: assert (!cnt_we_o && !z_we_o);
    end
    if (cnt_we_o) begin
      a_r8_dec_by_one: assert (cnt_o == cnt_i - {{(CNT_W-1){1'b0}}, 1'b1});
      a_r8_z_from_count: assert (z_o == (cnt_i == {{(CNT_W-1){1'b0}}, 1'b1}));
      a_r8_take_nonzero: assert (taken_o == (cnt_o != '0));
    end
    if (!hit_o) begin
      a_r10_miss_quiet: assert (!taken_o && !cnt_we_o && !z_we_o && next_pc_o == pc_i);
    end
    if (opcode_i == 8'h20 || opcode_i == 8'h30) begin
      a_r3_always_taken: assert (taken_o);
    end
    if (opcode_i == 8'h21 || opcode_i == 8'h31) begin
      a_r3_never_taken: assert (!taken_o);
    end
    if (opcode_i[7:4] == 4'h2 && !taken_o) begin
      a_r1_short_fallthrough: assert (next_pc_o == pc_i + {{(PC_W-2){1'b0}}, 2'd2});
    end
  end
endmodule

bind branch_loop_unit bl_checker #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .pc_i      (pc_i),
  .opcode_i  (opcode_i),
  .cnt_i     (cnt_i),
  .next_pc_o (next_pc_o),
  .taken_o   (taken_o),
  .hit_o     (hit_o),
  .cnt_o     (cnt_o),
  .cnt_we_o  (cnt_we_o),
  .z_o       (z_o),
  .z_we_o    (z_we_o)
);

// File: tb/sim_branch_loop_unit.sv
`timescale 1ns/1ps
module sim_branch_loop_unit;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] pc, disp_l, cnt, next_pc, cnt_out;
  logic [7:0]  op, sel, disp_s;
  logic        z, n, v, c;
  logic        taken, hit, cnt_we, z_out, z_we;
  logic [2:0]  idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int wd     = 0;

  branch_loop_unit u0 (
    .pc_i(pc), .opcode_i(op), .loop_reg_i(sel), .disp_short_i(disp_s),
    .disp_long_i(disp_l), .z_i(z), .n_i(n), .v_i(v), .c_i(c), .cnt_i(cnt),
    .next_pc_o(next_pc), .taken_o(taken), .hit_o(hit), .cnt_o(cnt_out),
    .cnt_we_o(cnt_we), .cnt_idx_o(idx), .z_o(z_out), .z_we_o(z_we)
  );

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000 && !done) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] p, input logic [7:0] o, input logic [7:0] s,
                       input logic [7:0] ds, input logic [15:0] dl,
                       input logic [3:0] f, input logic [15:0] k);
    @(negedge clk);
    pc = p; op = o; sel = s; disp_s = ds; disp_l = dl;
    {z, n, v, c} = f; cnt = k;
    #1;
  endtask

  function automatic logic ref_cond(input logic [3:0] cc, input logic [3:0] f);
    logic fz, fn, fv, fc;
    {fz, fn, fv, fc} = f;
    case (cc)
      4'h0: return 1'b1;
      4'h1: return 1'b0;
      4'h2: return !fc && !fz;
      4'h3: return fc || fz;
      4'h4: return !fc;
      4'h5: return fc;
      4'h6: return !fz;
      4'h7: return fz;
      4'h8: return !fv;
      4'h9: return fv;
      4'hA: return !fn;
      4'hB: return fn;
      4'hC: return fn == fv;
      4'hD: return fn != fv;
      4'hE: return !fz && (fn == fv);
      default: return fz || (fn != fv);
    endcase
  endfunction

  // R10: idle / unknown opcode
  task automatic t_idle();
    apply(16'h1234, 8'h00, 8'hB8, 8'h10, 16'h0010, 4'h0, 16'h0005);
    chk("R10 hit", hit, 0);
    chk("R10 taken", taken, 0);
    chk("R10 next_pc", next_pc, 16'h1234);
    chk("R10 cnt_we", cnt_we, 0);
    chk("R10 z_we", z_we, 0);
  endtask

  // R1 R3 R4 R5: every short condition with every flag pattern
  task automatic t_short_all();
    for (int d = 0; d < 2; d++) begin
      for (int cc = 0; cc < 16; cc++) begin
        for (int f = 0; f < 16; f++) begin
          logic [7:0]  ds;
          logic        exp_t;
          logic [15:0] exp_pc;
          ds = (d == 0) ? 8'h10 : 8'hF0;
          apply(16'h1000, {4'h2, cc[3:0]}, 8'h00, ds, 16'h0000, f[3:0], 16'h0003);
          exp_t  = ref_cond(cc[3:0], f[3:0]);
          exp_pc = exp_t ? 16'h1002 + {{8{ds[7]}}, ds} : 16'h1002;
          chk(cc < 12 ? "R3 short taken" : "R4 short taken", taken, exp_t);
          chk("R1 short next_pc", next_pc, exp_pc);
          chk("R5 short no write", {cnt_we, z_we, z_out}, {2'b00, f[3]});
        end
      end
    end
  endtask

  // R2 R4 R5: long branches
  task automatic t_long();
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f += 5) begin
        logic exp_t;
        apply(16'h4000, {4'h3, cc[3:0]}, 8'hBB, 8'h00, 16'h8000, f[3:0], 16'h0001);
        exp_t = ref_cond(cc[3:0], f[3:0]);
        chk(cc < 12 ? "R3 long taken" : "R4 long taken", taken, exp_t);
        chk("R2 long next_pc", next_pc, exp_t ? 16'hC003 : 16'h4003);
        chk("R5 long no write", {cnt_we, z_we}, 2'b00);
      end
    end
  endtask

  // R9: wraparound
  task automatic t_wrap();
    apply(16'hFFFF, 8'h20, 8'h00, 8'h7F, 16'h0000, 4'h0, 16'h0);
    chk("R9 short wrap", next_pc, 16'h0080);
    apply(16'hFFFE, 8'h30, 8'h00, 8'h00, 16'h0010, 4'h0, 16'h0);
    chk("R9 long wrap", next_pc, 16'h0011);
    apply(16'h0001, 8'h20, 8'h00, 8'h80, 16'h0000, 4'h0, 16'h0);
    chk("R9 short back wrap", next_pc, 16'hFF83);
    apply(16'hFFFE, 8'h31, 8'h00, 8'h00, 16'h0010, 4'h0, 16'h0);
    chk("R9 fallthrough wrap", next_pc, 16'h0001);
  endtask

  // R7: early exit on Z
  task automatic t_loop_exit();
    apply(16'h2000, 8'h06, 8'hBA, 8'hF0, 16'h0, 4'b0000, 16'h0009);
    chk("R7 zclr next_pc", next_pc, 16'h2003);
    chk("R7 zclr taken", taken, 0);
    chk("R7 zclr writes", {cnt_we, z_we}, 2'b00);
    chk("R7 zclr cnt", cnt_out, 16'h0009);
    chk("R7 zclr z", z_out, 0);
    apply(16'h2000, 8'h07, 8'hBA, 8'hF0, 16'h0, 4'b1000, 16'h0009);
    chk("R7 zset next_pc", next_pc, 16'h2003);
    chk("R7 zset writes", {cnt_we, z_we, taken}, 3'b000);
    chk("R7 zset z", z_out, 1);
  endtask

  // R8: decrement path
  task automatic t_loop_dec();
    apply(16'h2000, 8'h01, 8'hB9, 8'hF0, 16'h0, 4'b1000, 16'h0005);
    chk("R8 cnt", cnt_out, 16'h0004);
    chk("R8 we", {cnt_we, z_we}, 2'b11);
    chk("R8 z", z_out, 0);
    chk("R8 taken", taken, 1);
    chk("R8 next_pc back", next_pc, 16'h1FF3);
    apply(16'h2000, 8'h01, 8'hB9, 8'h20, 16'h0, 4'b0000, 16'h0001);
    chk("R8 last cnt", cnt_out, 16'h0000);
    chk("R8 last z", z_out, 1);
    chk("R8 last taken", taken, 0);
    chk("R8 last next_pc", next_pc, 16'h2003);
    apply(16'h2000, 8'h06, 8'hB9, 8'h20, 16'h0, 4'b1000, 16'h0000);
    chk("R8 underflow cnt", cnt_out, 16'hFFFF);
    chk("R8 underflow taken", {taken, z_out}, 2'b10);
    chk("R8 underflow next_pc", next_pc, 16'h2023);
    apply(16'h2000, 8'h07, 8'hB9, 8'h20, 16'h0, 4'b0000, 16'h0002);
    chk("R8 zset runs", {cnt_we, taken}, 2'b11);
  endtask

  // R6 R10: select byte decode
  task automatic t_loop_sel();
    for (int i = 0; i < 8; i++) begin
      apply(16'h3000, 8'h01, 8'hB8 + i[7:0], 8'h04, 16'h0, 4'h0, 16'h0003);
      chk("R6 hit", hit, 1);
      chk("R6 idx", idx, i[2:0]);
    end
    apply(16'h3000, 8'h01, 8'hB7, 8'h04, 16'h0, 4'h0, 16'h0003);
    chk("R6 sel below", {hit, cnt_we, taken}, 3'b000);
    chk("R10 sel below pc", next_pc, 16'h3000);
    apply(16'h3000, 8'h06, 8'hC0, 8'h04, 16'h0, 4'h8, 16'h0003);
    chk("R6 sel above", {hit, cnt_we, z_we}, 3'b000);
    apply(16'h3000, 8'h02, 8'hB8, 8'h04, 16'h0, 4'h0, 16'h0003);
    chk("R10 other opcode", {hit, cnt_we, taken}, 3'b000);
  endtask

  initial begin
    pc = '0; op = '0; sel = '0; disp_s = '0; disp_l = '0;
    {z, n, v, c} = 4'h0; cnt = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_idle();
    t_short_all();
    t_long();
    t_wrap();
    t_loop_exit();
    t_loop_dec();
    t_loop_sel();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule